// File: doc/BRIEF.md
# Interrupting Serial Port Register Interface

This block is the processor-facing register file of a byte-wide serial port that hangs off an asynchronous 8-bit bus. The processor reaches it through an active-low chip select, active-low read and write strobes and a 4-bit register offset. The bit-level line coding stays in neighbouring shifters. The receive shifter hands over finished bytes through a one-cycle valid pulse. The transmit shifter takes bytes from a valid/ready pair.

The strobes arrive without any relation to the block clock. Each one passes through a synchronizer, and each register side effect happens exactly once per strobe, however long the strobe is held. Read data comes from a snapshot taken when the strobe is recognised, and it is presented together with an output enable for the bus buffer.

An active-low interrupt line is driven whenever an enabled cause is pending. The causes are a received byte waiting to be read and an empty transmit holding register. A cause stays pending until software removes it with the matching register access. An interrupt service routine that returns without that access is therefore interrupted again.

Top module: `serint_regs`

## Requirements
- R1: After reset `irq_n` is 1, `rd_oe` is 0 and `tx_valid` is 0. The status register reads 8'h02 (only the transmit-empty bit set), and the interrupt-enable register reads 8'h00.
- R2: `rd_oe` is 1 only while `cs_n` and `rd_n` are both 0. Otherwise it is 0 and `rd_data` is 0.
- R3: Offsets 4 to 15 read as 8'h00. Writes to them change no register and no output.
- R4: A read or write strobe given while `cs_n` is 1 has no effect on any register, and `rd_oe` stays 0.
- R5: A `rx_valid` pulse stores `rx_data` and sets status bit 0 (receive full). A read of offset 0 returns the byte and clears bit 0.
- R6: A byte that arrives while receive full is set sets status bit 2 (overrun), and the newest byte is kept. A read of offset 2 returns the status before the clear and then clears overrun.
- R7: A write to offset 1 loads the byte, clears status bit 1 (transmit empty), and raises `tx_valid` with the byte on `tx_data`. A cycle with `tx_valid` and `tx_ready` both 1 drops `tx_valid` and sets bit 1 again.
- R8: Offset 3 is read/write. Bit 0 enables the receive cause and bit 1 enables the transmit cause. `irq_n` is 0 exactly when an enabled cause is pending.
- R9: A pending cause keeps `irq_n` at 0 for any number of cycles and across reads of other registers. Only a read of offset 0 (receive), a write of offset 1 (transmit) or disabling the cause releases it.
- R10: A strobe fires its side effect once, a fixed three clock edges after its falling edge. A byte that arrives while a read of offset 0 is still held stays pending. A transmit byte accepted while its write strobe is still held is not loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data from the bus |
| rd_data | output | 8 | Read data toward the bus, 0 when not enabled |
| rd_oe | output | 1 | Bus buffer output enable |
| irq_n | output | 1 | Active-low interrupt request |
| rx_valid | input | 1 | One-cycle pulse: received byte ready |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
The hardest case to reach is a second event that lands while a strobe is still held low after its side effect has fired. Examples are a byte arriving in the middle of a long receive read, or the transmitter taking the byte in the middle of a long write. A level-sensitive design would clear or reload a second time, and the error shows only in later status. The bench reaches this case by splitting each bus access into a start phase and an end phase. It injects the receive pulse or the transmit acceptance between the two, and it then reads the status.

// File: rtl/serint_pkg.sv
package serint_pkg;

   // register offsets (decoded by software, so fixed)
   localparam int unsigned OFS_RXD  = 0;
   localparam int unsigned OFS_TXD  = 1;
   localparam int unsigned OFS_STAT = 2;
   localparam int unsigned OFS_IEN  = 3;

   // status bit positions
   localparam int unsigned ST_RXFULL  = 0;
   localparam int unsigned ST_TXEMPTY = 1;
   localparam int unsigned ST_OVR     = 2;

   // enable bit positions
   localparam int unsigned IE_RX = 0;
   localparam int unsigned IE_TX = 1;
   localparam int unsigned IE_W  = 2;

   typedef enum logic [2:0] {
      SEL_RXD,
      SEL_TXD,
      SEL_STAT,
      SEL_IEN,
      SEL_NONE
   } reg_sel_t;

   typedef struct packed {
      logic rx_read;
      logic stat_read;
      logic tx_write;
      logic ie_write;
   } reg_fx_t;

endpackage

// File: rtl/serint_strobe_sync.sv
module serint_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serint_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   // sh[STAGES-1] is the synchronized strobe, sh[STAGES] its previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], strobe_n};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];

   // R10: one event per strobe, never two in a row
   p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/serint_rx_path.sv
module serint_rx_path #(
   parameter int unsigned DATA_W       = 8,
   parameter bit          OVR_KEEP_NEW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rd_clear,
   input  logic              stat_read,
   output logic [DATA_W-1:0] rx_hold,
   output logic              rx_full,
   output logic              overrun
);

   logic collide;
   logic load;

   assign collide = rx_valid & rx_full & ~rd_clear;

   generate
      if (OVR_KEEP_NEW) begin : g_keep_new
         assign load = rx_valid;
      end else begin : g_keep_old
         assign load = rx_valid & (~rx_full | rd_clear);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx_hold <= '0;
      else if (load) rx_hold <= rx_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_full <= 1'b0;
      else if (rx_valid)  rx_full <= 1'b1;
      else if (rd_clear)  rx_full <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         overrun <= 1'b0;
      else if (collide)   overrun <= 1'b1;
      else if (stat_read) overrun <= 1'b0;
   end

   p_arrive_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rx_full);

   p_read_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !rx_valid) |=> !rx_full);

   p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full && !rd_clear) |=> overrun);

endmodule

// File: rtl/serint_tx_path.sv
module serint_tx_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_empty
);

   logic accept;

   assign accept = tx_valid & tx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_data <= '0;
      else if (wr_load) tx_data <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_valid <= 1'b0;
      else if (wr_load) tx_valid <= 1'b1;
      else if (accept)  tx_valid <= 1'b0;
   end

   assign tx_empty = ~tx_valid;

   p_load_presents_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> (tx_valid && tx_data == $past(wr_data)));

   p_accept_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !wr_load) |=> tx_empty);

endmodule

// File: rtl/serint_regs.sv
module serint_regs #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          OVR_KEEP_NEW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              irq_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready
);
   import serint_pkg::*;

   localparam int unsigned NUM_REGS = 1 << ADDR_W;

   generate
      if (DATA_W < IE_W || DATA_W < ST_OVR + 1) begin : g_bad_width
         $error("serint_regs: DATA_W too narrow for status and enable bits");
      end
      if (ADDR_W < 2 || NUM_REGS < OFS_IEN + 1) begin : g_bad_addr
         $error("serint_regs: ADDR_W must cover four registers");
      end
   endgenerate

   logic              rd_fall, wr_fall, rd_ev, wr_ev;
   reg_sel_t          sel;
   reg_fx_t           fx;
   logic [IE_W-1:0]   ie_q;
   logic [DATA_W-1:0] rx_hold, rd_snap, rd_mux, status;
   logic              rx_full, overrun, tx_empty;
   logic [IE_W-1:0]   cause;

   serint_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .fall(rd_fall));

   serint_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .fall(wr_fall));

   assign rd_ev = rd_fall & ~cs_n;
   assign wr_ev = wr_fall & ~cs_n;

   always_comb begin
      if      (addr == ADDR_W'(OFS_RXD))  sel = SEL_RXD;
      else if (addr == ADDR_W'(OFS_TXD))  sel = SEL_TXD;
      else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (addr == ADDR_W'(OFS_IEN))  sel = SEL_IEN;
      else                                sel = SEL_NONE;
   end

   always_comb begin
      fx           = '0;
      fx.rx_read   = rd_ev & (sel == SEL_RXD);
      fx.stat_read = rd_ev & (sel == SEL_STAT);
      fx.tx_write  = wr_ev & (sel == SEL_TXD);
      fx.ie_write  = wr_ev & (sel == SEL_IEN);
   end

   serint_rx_path #(.DATA_W(DATA_W), .OVR_KEEP_NEW(OVR_KEEP_NEW)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .rd_clear(fx.rx_read), .stat_read(fx.stat_read),
      .rx_hold(rx_hold), .rx_full(rx_full), .overrun(overrun));

   serint_tx_path #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .wr_load(fx.tx_write), .wr_data(wr_data), .tx_ready(tx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_empty(tx_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ie_q <= '0;
      else if (fx.ie_write) ie_q <= wr_data[IE_W-1:0];
   end

   always_comb begin
      status             = '0;
      status[ST_RXFULL]  = rx_full;
      status[ST_TXEMPTY] = tx_empty;
      status[ST_OVR]     = overrun;
   end

   always_comb begin
      case (sel)
         SEL_RXD:  rd_mux = rx_hold;
         SEL_STAT: rd_mux = status;
         SEL_IEN:  rd_mux = DATA_W'(ie_q);
         default:  rd_mux = '0;
      endcase
   end

   // snapshot taken in the same cycle the read side effect fires
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_snap <= '0;
      else if (rd_ev) rd_snap <= rd_mux;
   end

   assign rd_oe   = ~cs_n & ~rd_n;
   assign rd_data = rd_oe ? rd_snap : '0;

   assign cause[IE_RX] = rx_full;
   assign cause[IE_TX] = tx_empty;
   assign irq_n        = ~|(cause & ie_q);

   // R9: a pending interrupt is held until a register access intervenes
   p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !rd_ev && !wr_ev) |=> !irq_n);

   // R4: an unselected cycle cannot change the enable register
   p_unselected_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(ie_q));

   // R3: writes to reserved offsets leave the enables alone
   p_reserved_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && sel == SEL_NONE) |=> $stable(ie_q));

   // R2: no read data leaks while the buffer is disabled
   p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (rd_data == '0));

endmodule

// File: tb/serint_regs_test.sv
`timescale 1ns/1ps
module serint_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [3:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_oe, irq_n;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_ready = 1'b0;

   always #2.5 clk = ~clk;

   serint_regs uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
      .irq_n(irq_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

   int errors = 0;
   int checks = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   // reference state
   bit       m_full = 0, m_ovr = 0, m_empty = 1;
   bit [7:0] m_rx = 0, m_tx = 0;
   bit [1:0] m_ie = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] exp_read(input bit [3:0] a);
      case (a)
         4'd0:    return m_rx;
         4'd2:    return {5'b0, m_ovr, m_empty, m_full};
         4'd3:    return {6'b0, m_ie};
         default: return 8'h00;
      endcase
   endfunction

   // per-cycle comparison of the free-running outputs (R7, R8)
   always @(negedge clk) begin
      if (running) begin
         check(irq_n == !((m_full && m_ie[0]) || (m_empty && m_ie[1])),
               "R8 irq_n", irq_n, !((m_full && m_ie[0]) || (m_empty && m_ie[1])));
         check(tx_valid == !m_empty, "R7 tx_valid", tx_valid, !m_empty);
         if (tx_valid) check(tx_data == m_tx, "R7 tx_data", tx_data, m_tx);
      end
   end

   task automatic rd_start(input bit [3:0] a, input bit sel, output bit [7:0] v);
      bit [7:0] e;
      @(negedge clk);
      cs_n = !sel; addr = a; rd_n = 1'b0;
      repeat (3) @(posedge clk);
      e = exp_read(a);
      #1;
      if (sel) begin
         if (a == 4'd0) m_full = 0;
         if (a == 4'd2) m_ovr = 0;
      end
      @(negedge clk);
      v = rd_data;
      if (sel) begin
         check(rd_oe == 1'b1, "R2 oe during read", rd_oe, 1);
         check(rd_data == e, "R5/R6 read data", rd_data, e);
      end else begin
         check(rd_oe == 1'b0, "R4 oe unselected", rd_oe, 0);
      end
   endtask

   task automatic rd_end();
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
      #1;
      check(rd_oe == 1'b0 && rd_data == 8'h00, "R2 oe released", rd_oe, 0);
   endtask

   task automatic bus_rd(input bit [3:0] a, output bit [7:0] v);
      rd_start(a, 1'b1, v);
      rd_end();
   endtask

   task automatic wr_start(input bit [3:0] a, input bit [7:0] d, input bit sel);
      @(negedge clk);
      cs_n = !sel; addr = a; wr_data = d; wr_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      if (sel) begin
         if (a == 4'd1) begin m_tx = d; m_empty = 0; end
         if (a == 4'd3) m_ie = d[1:0];
      end
   endtask

   task automatic wr_end();
      @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic bus_wr(input bit [3:0] a, input bit [7:0] d);
      wr_start(a, d, 1'b1);
      wr_end();
   endtask

   task automatic rx_push(input bit [7:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      if (m_full) m_ovr = 1;
      m_rx = d; m_full = 1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic tx_accept();
      @(negedge clk);
      tx_ready = 1'b1;
      @(posedge clk); #1;
      m_empty = 1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      bit [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
      check(rd_oe == 1'b0, "R1 rd_oe", rd_oe, 0);
      check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
      running = 1'b1;
      bus_rd(4'd2, v); check(v == 8'h02, "R1 status", v, 8'h02);
      bus_rd(4'd3, v); check(v == 8'h00, "R1 enables", v, 8'h00);

      // R5 receive path
      rx_push(8'hA5);
      bus_rd(4'd2, v); check(v == 8'h03, "R5 status full", v, 8'h03);
      bus_rd(4'd0, v); check(v == 8'hA5, "R5 rx byte", v, 8'hA5);
      bus_rd(4'd2, v); check(v == 8'h02, "R5 status cleared", v, 8'h02);

      // R6 overrun
      rx_push(8'h11);
      rx_push(8'h22);
      bus_rd(4'd0, v); check(v == 8'h22, "R6 newest kept", v, 8'h22);
      bus_rd(4'd2, v); check(v == 8'h06, "R6 overrun flagged", v, 8'h06);
      bus_rd(4'd2, v); check(v == 8'h02, "R6 overrun cleared", v, 8'h02);

      // R7 transmit path
      bus_wr(4'd1, 8'h3C);
      @(negedge clk);
      check(tx_valid && tx_data == 8'h3C, "R7 presented", tx_data, 8'h3C);
      bus_rd(4'd2, v); check(v == 8'h00, "R7 not empty", v, 8'h00);
      tx_accept();
      bus_rd(4'd2, v); check(v == 8'h02, "R7 empty again", v, 8'h02);

      // R8 / R9 interrupt
      bus_wr(4'd3, 8'h01);
      bus_rd(4'd3, v); check(v == 8'h01, "R8 enable readback", v, 8'h01);
      check(irq_n == 1'b1, "R8 idle", irq_n, 1);
      rx_push(8'h5E);
      @(negedge clk); check(irq_n == 1'b0, "R8 rx irq", irq_n, 0);
      bus_rd(4'd2, v);
      repeat (20) @(negedge clk);
      check(irq_n == 1'b0, "R9 held", irq_n, 0);
      bus_rd(4'd0, v);
      @(negedge clk); check(irq_n == 1'b1, "R9 released by rx read", irq_n, 1);
      bus_wr(4'd3, 8'h02);
      @(negedge clk); check(irq_n == 1'b0, "R8 tx irq", irq_n, 0);
      bus_wr(4'd1, 8'h77);
      @(negedge clk); check(irq_n == 1'b1, "R9 released by tx write", irq_n, 1);
      tx_accept();
      @(negedge clk); check(irq_n == 1'b0, "R9 tx cause again", irq_n, 0);
      bus_wr(4'd3, 8'h00);
      @(negedge clk); check(irq_n == 1'b1, "R8 disabled", irq_n, 1);

      // R4 unselected strobes
      rx_push(8'h99);
      rd_start(4'd0, 1'b0, v); rd_end();
      wr_start(4'd3, 8'h03, 1'b0); wr_end();
      wr_start(4'd1, 8'hEE, 1'b0); wr_end();
      @(negedge clk); check(tx_valid == 1'b0, "R4 no tx load", tx_valid, 0);
      bus_rd(4'd2, v); check(v == 8'h03, "R4 rx still full", v, 8'h03);
      bus_rd(4'd3, v); check(v == 8'h00, "R4 enables kept", v, 8'h00);
      bus_rd(4'd0, v);

      // R3 reserved offsets
      bus_wr(4'd4, 8'hFF);
      bus_wr(4'd15, 8'hFF);
      bus_rd(4'd3, v); check(v == 8'h00, "R3 enables untouched", v, 8'h00);
      @(negedge clk); check(tx_valid == 1'b0, "R3 no tx load", tx_valid, 0);
      bus_rd(4'd7, v); check(v == 8'h00, "R3 reserved reads 0", v, 8'h00);
      bus_rd(4'd15, v); check(v == 8'h00, "R3 top offset reads 0", v, 8'h00);

      // R10 held strobes
      rx_push(8'h5A);
      rd_start(4'd0, 1'b1, v);
      check(v == 8'h5A, "R10 held read data", v, 8'h5A);
      rx_push(8'h6B);
      repeat (10) @(negedge clk);
      rd_end();
      bus_rd(4'd2, v); check(v == 8'h03, "R10 single clear", v, 8'h03);
      bus_rd(4'd0, v); check(v == 8'h6B, "R10 late byte kept", v, 8'h6B);
      wr_start(4'd1, 8'hC3, 1'b1);
      tx_accept();
      repeat (10) @(negedge clk);
      wr_end();
      repeat (3) @(negedge clk);
      check(tx_valid == 1'b0, "R10 single load", tx_valid, 0);

      repeat (4) @(negedge clk);
      running = 1'b0;
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule